// File: doc/BRIEF.md
# Spin-Lock Acquire Agent with Polling and Backoff

This block obtains and gives back a spin lock that lives as one word in shared memory, on behalf of a local client. The client asks for the lock with a one-cycle `acq_req` pulse. The agent then reads the lock word with plain loads until it reads zero. Only at that point does it issue one atomic test-and-set. If the atomic operation returns a nonzero old value, another agent won the race. The agent then goes quiet for a delay, polls again, and doubles the delay after each further loss up to a fixed ceiling.

When the atomic operation returns zero, the agent raises `acquired`. It holds it until the client pulses `rel_req`, which makes the agent store zero to the lock word. A saturating count of lost atomic attempts is available on an output. The memory system and the unit that makes the test-and-set atomic are outside the block. The agent drives a request port that waits for a ready signal and keeps at most one request outstanding, and it takes one response per request.

Top module: `spinlock_agent`

## Requirements
- R1: After reset `acquired` is 0, `mem_req_valid` is 0 and `fail_cnt` is 0.
- R2: While the most recent load has returned a nonzero word, the agent issues only loads (op code 0) and never a test-and-set.
- R3: On the cycle after a load response of zero, the agent presents a test-and-set request (op code 1) with write data 1.
- R4: A test-and-set response of zero makes `acquired` go high on the next cycle. A nonzero response sends the agent into a backoff wait and then back to polling.
- R5: The k-th consecutive lost test-and-set (k counted from 1 since the last successful acquire) is followed by exactly min(4*2^(k-1), 256) cycles with no request before the next load request appears.
- R6: After a successful acquire, the next lost attempt again waits 4 cycles.
- R7: A `rel_req` pulse while the lock is held drops `acquired` on the next cycle and issues one store (op code 2) with write data 0. The agent goes idle once the store's response arrives.
- R8: A `rel_req` pulse while the lock is not held is ignored: no memory request follows.
- R9: An `acq_req` pulse while the lock is held is ignored: `acquired` stays high and no memory request follows.
- R10: `fail_cnt` rises by one for each lost test-and-set and stays at 2^FCW-1 once it gets there.
- R11: A request that is not accepted keeps its op and data unchanged until `mem_req_ready`, and no new request is presented while one awaits its response.
- R12: Every request carries `lock_addr` as its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | One-cycle request to obtain the lock |
| rel_req | input | 1 | One-cycle request to give the lock back |
| acquired | output | 1 | High while the lock is held for the client |
| lock_addr | input | AW | Address of the lock word |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_op | output | 2 | 0 load, 1 test-and-set, 2 store |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data (1 for test-and-set, 0 for store) |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_data | input | DW | Old lock word for load and test-and-set |
| fail_cnt | output | FCW | Saturating count of lost test-and-set attempts |

## Verification
The bench scripts the lock word so that loads see it busy for a set number of reads and test-and-set loses a set number of times. It measures each quiet gap after a loss. A design that skipped the read-only spin, doubled the delay from the wrong start, let the delay run past 256, or kept the grown delay after a win would show a wrong load or atomic count or a wrong gap. An eight-loss run reaches the ceiling twice, and a later run drives the failure count past its saturation point. Release and acquire pulses are given in the wrong states, and the bench confirms that no memory traffic follows them.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_POLL    = 3'd1,
    ST_TAS     = 3'd2,
    ST_BACKOFF = 3'd3,
    ST_HELD    = 3'd4,
    ST_RELEASE = 3'd5
  } lk_state_t;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_TAS   = 2'd1,
    OP_STORE = 2'd2
  } mem_op_t;

  // Doubling step of the backoff delay, clipped at the ceiling.
  function automatic int unsigned grow_delay(input int unsigned cur, input int unsigned ceil_v);
    int unsigned dbl;
    dbl = cur << 1;
    return (dbl > ceil_v) ? ceil_v : dbl;
  endfunction

endpackage

// File: rtl/backoff_timer.sv
module backoff_timer import spinlock_pkg::*; #(
  parameter int unsigned MIN_DLY = 4,
  parameter int unsigned MAX_DLY = 256,
  localparam int DLY_W = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fail_evt,
  input  logic             win_evt,
  output logic             done,
  output logic [DLY_W-1:0] cur_dly
);

  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q <= DLY_W'(MIN_DLY);
      cnt_q <= '0;
    end else if (fail_evt) begin
      cnt_q <= dly_q - DLY_W'(1);
      dly_q <= DLY_W'(grow_delay(32'(dly_q), MAX_DLY));
    end else begin
      if (win_evt) dly_q <= DLY_W'(MIN_DLY);
      if (cnt_q != '0) cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  assign done    = (cnt_q == '0);
  assign cur_dly = dly_q;

endmodule

// File: rtl/fail_counter.sv
module fail_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (inc && cnt_q != '1) cnt_q <= cnt_q + W'(1);
  end

  assign count = cnt_q;

endmodule

// File: rtl/spinlock_agent.sv
module spinlock_agent import spinlock_pkg::*; #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned MIN_DLY = 4,
  parameter int unsigned MAX_DLY = 256,
  parameter int unsigned FCW     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_req,
  input  logic          rel_req,
  output logic          acquired,
  input  logic [AW-1:0] lock_addr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [1:0]    mem_req_op,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [FCW-1:0] fail_cnt
);

  localparam int DLY_W = $clog2(MAX_DLY + 1);

  lk_state_t st_q, st_d;
  logic      pend_q;
  mem_op_t   op_sel;

  // Named internal events
  logic lock_free, issuing;
  logic evt_fire, evt_rsp, evt_seen_free, evt_tas_win, evt_tas_fail, evt_rel_done;
  logic tmr_done;
  logic [DLY_W-1:0] tmr_dly;

  assign lock_free     = (mem_rsp_data == '0);
  assign issuing       = (st_q == ST_POLL) || (st_q == ST_TAS) || (st_q == ST_RELEASE);
  assign evt_fire      = mem_req_valid && mem_req_ready;
  assign evt_rsp       = mem_rsp_valid && pend_q;
  assign evt_seen_free = evt_rsp && (st_q == ST_POLL) && lock_free;
  assign evt_tas_win   = evt_rsp && (st_q == ST_TAS) && lock_free;
  assign evt_tas_fail  = evt_rsp && (st_q == ST_TAS) && !lock_free;
  assign evt_rel_done  = evt_rsp && (st_q == ST_RELEASE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (acq_req)       st_d = ST_POLL;
      ST_POLL:    if (evt_seen_free) st_d = ST_TAS;
      ST_TAS: begin
        if (evt_tas_win)       st_d = ST_HELD;
        else if (evt_tas_fail) st_d = ST_BACKOFF;
      end
      ST_BACKOFF: if (tmr_done)      st_d = ST_POLL;
      ST_HELD:    if (rel_req)       st_d = ST_RELEASE;
      ST_RELEASE: if (evt_rel_done)  st_d = ST_IDLE;
      default:                       st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (evt_fire)     pend_q <= 1'b1;
      else if (evt_rsp) pend_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_TAS:     op_sel = OP_TAS;
      ST_RELEASE: op_sel = OP_STORE;
      default:    op_sel = OP_LOAD;
    endcase
  end

  assign mem_req_valid = issuing && !pend_q;
  assign mem_req_op    = op_sel;
  assign mem_req_addr  = lock_addr;
  assign mem_req_wdata = (op_sel == OP_TAS) ? DW'(1) : '0;
  assign acquired      = (st_q == ST_HELD);

  backoff_timer #(
    .MIN_DLY(MIN_DLY),
    .MAX_DLY(MAX_DLY)
  ) tmr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fail_evt(evt_tas_fail),
    .win_evt (evt_tas_win),
    .done    (tmr_done),
    .cur_dly (tmr_dly)
  );

  fail_counter #(
    .W(FCW)
  ) fcnt_i (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (evt_tas_fail),
    .count(fail_cnt)
  );

endmodule

// File: rtl/spinlock_agent_chk.sv
module spinlock_agent_chk import spinlock_pkg::*; #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned MIN_DLY = 4,
  parameter int unsigned MAX_DLY = 256,
  parameter int unsigned FCW     = 4,
  localparam int DLY_W = $clog2(MAX_DLY + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acquired,
  input logic [AW-1:0]    lock_addr,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [1:0]       mem_req_op,
  input logic [AW-1:0]    mem_req_addr,
  input logic [DW-1:0]    mem_req_wdata,
  input logic             mem_rsp_valid,
  input logic [DW-1:0]    mem_rsp_data,
  input logic [FCW-1:0]   fail_cnt,
  input logic [DLY_W-1:0] tmr_dly
);

  logic       out_q;
  logic [1:0] out_op_q;
  logic       busy_seen_q;
  logic       rsp_load_free, rsp_tas_free;

  assign rsp_load_free = mem_rsp_valid && out_q && out_op_q == OP_LOAD && mem_rsp_data == '0;
  assign rsp_tas_free  = mem_rsp_valid && out_q && out_op_q == OP_TAS  && mem_rsp_data == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q       <= 1'b0;
      out_op_q    <= OP_LOAD;
      busy_seen_q <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) begin
        out_q    <= 1'b1;
        out_op_q <= mem_req_op;
      end else if (mem_rsp_valid) begin
        out_q <= 1'b0;
      end
      if (mem_rsp_valid && out_q && out_op_q == OP_LOAD)
        busy_seen_q <= (mem_rsp_data != '0);
    end
  end

  AST_NO_TAS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op == OP_TAS |-> !busy_seen_q); // R2
  AST_TAS_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_load_free |=> mem_req_valid && mem_req_op == OP_TAS && mem_req_wdata == DW'(1)); // R3
  AST_ACQ_FROM_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acquired) |-> $past(rsp_tas_free)); // R4
  AST_DELAY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_dly >= DLY_W'(MIN_DLY) && tmr_dly <= DLY_W'(MAX_DLY)); // R5
  AST_STORE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_op == OP_STORE |-> mem_req_wdata == '0); // R7
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    acquired |-> !mem_req_valid); // R9
  AST_FAIL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fail_cnt) |-> fail_cnt == FCW'($past(fail_cnt) + FCW'(1))); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_op) && $stable(mem_req_wdata)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> !mem_req_valid); // R11
  AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr == lock_addr); // R12

endmodule

bind spinlock_agent spinlock_agent_chk #(
  .AW(AW), .DW(DW), .MIN_DLY(MIN_DLY), .MAX_DLY(MAX_DLY), .FCW(FCW)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .acquired     (acquired),
  .lock_addr    (lock_addr),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_op   (mem_req_op),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_data (mem_rsp_data),
  .fail_cnt     (fail_cnt),
  .tmr_dly      (tmr_dly)
);

// File: tb/spinlock_agent_tb_top.sv
`timescale 1ns/1ps
module spinlock_agent_tb_top;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int FCW = 4;
  localparam logic [AW-1:0] LOCK_A = 32'h0000_4A40;
  localparam int ROWS = 5;
  // busy reads before first attempt, lost attempts, busy reads after each loss
  localparam int VEC [ROWS][3] = '{
    '{0, 0, 0}, '{3, 0, 0}, '{0, 2, 1}, '{2, 3, 0}, '{1, 8, 0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acq_req = 1'b0, rel_req = 1'b0;
  logic acquired;
  logic mem_req_valid, mem_req_ready = 1'b1;
  logic [1:0] mem_req_op;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [FCW-1:0] fail_cnt;

  always #4 clk = ~clk;

  spinlock_agent #(.AW(AW), .DW(DW), .FCW(FCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
    .acquired(acquired), .lock_addr(LOCK_A),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_op(mem_req_op), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .fail_cnt(fail_cnt)
  );

  int checks = 0, errors = 0;
  int busy_left = 0, fails_left = 0, busy_after = 0;
  int n_load = 0, n_tas = 0, n_store = 0, n_fire = 0, bad_addr = 0, bad_wdata = 0;
  int gaps [16];
  int n_gaps = 0, gap = 0, cyc = 0;
  bit acc_pend = 0, resp_fail = 0, measuring = 0;
  logic [DW-1:0] resp_val = '0;
  logic [DW-1:0] last_store = '1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Memory model, driven on falling edges
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (measuring) begin
        if (mem_req_valid && mem_req_op == 2'd0) begin
          if (n_gaps < 16) gaps[n_gaps] = gap;
          n_gaps++;
          measuring = 0;
        end else gap++;
      end
      if (acc_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = resp_val;
        acc_pend = 0;
        if (resp_fail) begin measuring = 1; gap = 0; end
      end else begin
        mem_rsp_valid = 1'b0;
      end
      mem_req_ready = (cyc % 3) != 2;
      if (mem_req_valid && mem_req_ready) begin
        acc_pend = 1; resp_fail = 0; n_fire++;
        if (mem_req_addr != LOCK_A) bad_addr++;
        case (mem_req_op)
          2'd0: begin
            n_load++;
            if (busy_left > 0) begin resp_val = 1; busy_left--; end
            else resp_val = 0;
          end
          2'd1: begin
            n_tas++;
            if (mem_req_wdata != 1) bad_wdata++;
            if (fails_left > 0) begin
              resp_val = 1; fails_left--; busy_left = busy_after; resp_fail = 1;
            end else resp_val = 0;
          end
          default: begin n_store++; last_store = mem_req_wdata; resp_val = 0; end
        endcase
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic pulse_acq();
    @(negedge clk); acq_req = 1'b1;
    @(negedge clk); acq_req = 1'b0;
  endtask

  task automatic pulse_rel();
    @(negedge clk); rel_req = 1'b1;
    @(negedge clk); rel_req = 1'b0;
  endtask

  int fail_total = 0;

  task automatic run_row(input int b0, input int nf, input int ba, input string tag);
    int f0, l0, t0, w;
    @(negedge clk);
    busy_left = b0; fails_left = nf; busy_after = ba;
    n_gaps = 0; f0 = n_fire; l0 = n_load; t0 = n_tas; w = 0;
    pulse_acq();
    while (!acquired && w < 4000) begin @(negedge clk); w++; end
    chk(acquired == 1'b1, "R4", {tag, " acquired"}, int'(acquired), 1);
    chk(n_load - l0 == b0 + 1 + nf * (ba + 1), "R2", {tag, " loads"}, n_load - l0, b0 + 1 + nf * (ba + 1));
    chk(n_tas - t0 == nf + 1, "R3", {tag, " tas count"}, n_tas - t0, nf + 1);
    chk(n_gaps == nf, "R5", {tag, " gap count"}, n_gaps, nf);
    for (int k = 0; k < nf && k < 16; k++) begin
      int e;
      e = (4 << k) > 256 ? 256 : (4 << k);
      chk(gaps[k] == e, k == 0 ? "R6" : "R5", {tag, " backoff gap"}, gaps[k], e);
    end
    fail_total += nf;
    chk(int'(fail_cnt) == (fail_total > 15 ? 15 : fail_total), "R10", {tag, " fail_cnt"},
        int'(fail_cnt), fail_total > 15 ? 15 : fail_total);
    // R9: acquire while holding
    f0 = n_fire;
    pulse_acq();
    repeat (6) @(negedge clk);
    chk(acquired == 1'b1 && n_fire == f0, "R9", {tag, " acq while held"}, n_fire - f0, 0);
    // R7: release
    f0 = n_store;
    @(negedge clk); rel_req = 1'b1;
    @(negedge clk); rel_req = 1'b0;
    chk(acquired == 1'b0, "R7", {tag, " acquired drop"}, int'(acquired), 0);
    repeat (6) @(negedge clk);
    chk(n_store - f0 == 1 && last_store == '0, "R7", {tag, " release store"}, n_store - f0, 1);
    // R8: release while idle
    f0 = n_fire;
    pulse_rel();
    repeat (6) @(negedge clk);
    chk(n_fire == f0 && acquired == 1'b0, "R8", {tag, " rel while idle"}, n_fire - f0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(acquired == 1'b0, "R1", "reset acquired", int'(acquired), 0);
    chk(mem_req_valid == 1'b0, "R1", "reset valid", int'(mem_req_valid), 0);
    chk(fail_cnt == '0, "R1", "reset fail_cnt", int'(fail_cnt), 0);
    rst_n = 1'b1;
    for (int r = 0; r < ROWS; r++) begin
      run_row(VEC[r][0], VEC[r][1], VEC[r][2], $sformatf("row%0d", r));
    end
    // Directed: push the failure count past saturation
    run_row(0, 5, 2, "saturate");
    chk(int'(fail_cnt) == 15, "R10", "fail_cnt saturated", int'(fail_cnt), 15);
    chk(bad_addr == 0, "R12", "request address", bad_addr, 0);
    chk(bad_wdata == 0, "R3", "tas write data", bad_wdata, 0);
    chk(n_fire == n_load + n_tas + n_store, "R11", "op codes", n_fire, n_load + n_tas + n_store);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule